// File: doc/BRIEF.md
# Performance-State Transition Sequencer

This block moves one clock/voltage domain between a small set of operating points. It takes a requested performance-state index from a governor, together with a thermal-alarm line. It drives a regulator voltage code and a clock-select code, ordering the two steps so that the clock never outruns the supply. When the voltage goes up, the new voltage is commanded first, and the clock changes only after the regulator confirms power-good. When the voltage goes down, the clock is lowered first and the voltage follows after the clock has locked.

Requests that arrive during a transition are not dropped. The newest one is remembered and serviced when the current move ends. A thermal alarm overrides the request and drives the domain to the slowest point; when the alarm clears, the remembered request is served again. If the regulator never confirms power-good, the block halts with an error flag and keeps the lower of the two clock settings.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the block is at state 3 (slowest), with regulator code 70 and clock select 2 applied, busy low and the error flag low.
- R2: State i is encoded as regulator code 100-10*i (units of 10 mV) and clock select 5-i (units of 400 MHz), so state 0 is 100/5, state 1 is 90/4, state 2 is 80/3 and state 3 is 70/2. A lower index is a faster point.
- R3: On a move to a faster state, the regulator code changes first. The clock select is raised only at an edge where power-good is sampled high, and power-good is ignored in the first wait cycle.
- R4: On a move to a slower state, the clock select changes first, and the regulator code is lowered exactly LOCK_CYC cycles later.
- R5: At every cycle, clock select times 10 is no greater than regulator code minus 50. This means the applied clock never exceeds what the applied voltage supports.
- R6: While the thermal alarm is high, an idle block moves to state 3 whatever the request. After the alarm clears, it moves to the most recent request.
- R7: If power-good does not arrive within pg_limit cycles of a regulator command, pg_err rises exactly pg_limit cycles after the command and the clock select is left unchanged. No further transition happens until reset.
- R8: On a faster move, cur_state updates exactly LOCK_CYC cycles after the clock select changes.
- R9: Requests accepted while busy are collapsed: only the latest one is served after the current transition ends.
- R10: A request equal to the current state causes no change on any actuator output, and busy stays low.
- R11: busy rises at the first edge that samples a request needing a move. It falls at the same edge where cur_state takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_state | input | SW | Requested state index |
| therm_alarm | input | 1 | Thermal alarm, forces the slowest state |
| pgood | input | 1 | Regulator power-good |
| pg_limit | input | TW | Power-good timeout in cycles |
| vreg_code | output | VW | Regulator voltage command |
| clk_sel | output | CW | Clock-generator select |
| busy | output | 1 | Transition in progress |
| cur_state | output | SW | Completed current state |
| pg_err | output | 1 | Power-good timeout flag |

## Verification
Two functions can coincide: request latching and an ongoing transition. A new request can land in the same cycle that a transition step happens, and a thermal alarm can arrive while a remembered request is still pending. The bench sends several requests during the power-good wait of an upward move, and raises the alarm just after one move ends. A scoreboard holds the expected ordered list of actuator and completion events, and it must see the older request dropped and the alarm target served in place of the pending request. A monitor also times the lock and timeout windows and checks the clock-versus-voltage bound on every cycle.

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NST      = 4,
  parameter int SW       = $clog2(NST),
  parameter int VW       = 8,
  parameter int CW       = 4,
  parameter int VTOP     = 100,
  parameter int VSTEP    = 10,
  parameter int CTOP     = 5,
  parameter int LOCK_CYC = 4,
  parameter int TW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [SW-1:0] req_state,
  input  logic          therm_alarm,
  input  logic          pgood,
  input  logic [TW-1:0] pg_limit,
  output logic [VW-1:0] vreg_code,
  output logic [CW-1:0] clk_sel,
  output logic          busy,
  output logic [SW-1:0] cur_state,
  output logic          pg_err
);
  localparam logic [SW-1:0] LOW = SW'(NST - 1);

  typedef enum logic [2:0] {IDLE, VUP, LOCK, VDN, FAULT} st_t;

  function automatic logic [VW-1:0] vcode_of(input logic [SW-1:0] i);
    return VW'(VTOP - VSTEP * int'(i));
  endfunction

  function automatic logic [CW-1:0] csel_of(input logic [SW-1:0] i);
    return CW'(CTOP - int'(i));
  endfunction

  st_t           st;
  logic [SW-1:0] want, tgt;
  logic          down;
  logic [TW-1:0] cnt;

  wire [SW-1:0] want_n   = req_valid ? req_state : want;
  wire [SW-1:0] eff      = therm_alarm ? LOW : want_n;
  wire          expired  = (cnt == pg_limit - TW'(1));
  wire          pg_seen  = pgood && (cnt != '0);
  wire          locked   = (cnt == TW'(LOCK_CYC - 1));

  assign busy = (st == VUP) || (st == LOCK) || (st == VDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      want      <= LOW;
      tgt       <= LOW;
      down      <= 1'b0;
      cnt       <= '0;
      vreg_code <= vcode_of(LOW);
      clk_sel   <= csel_of(LOW);
      cur_state <= LOW;
      pg_err    <= 1'b0;
    end else begin
      want <= want_n;
      case (st)
        IDLE: if (eff != cur_state) begin
          tgt <= eff;
          cnt <= '0;
          if (eff < cur_state) begin
            down      <= 1'b0;
            vreg_code <= vcode_of(eff);
            st        <= VUP;
          end else begin
            down    <= 1'b1;
            clk_sel <= csel_of(eff);
            st      <= LOCK;
          end
        end
        VUP: if (pg_seen) begin
          clk_sel <= csel_of(tgt);
          cnt     <= '0;
          st      <= LOCK;
        end else if (expired) begin
          pg_err <= 1'b1;
          st     <= FAULT;
        end else begin
          cnt <= cnt + TW'(1);
        end
        LOCK: if (locked) begin
          cnt <= '0;
          if (down) begin
            vreg_code <= vcode_of(tgt);
            st        <= VDN;
          end else begin
            cur_state <= tgt;
            st        <= IDLE;
          end
        end else begin
          cnt <= cnt + TW'(1);
        end
        VDN: if (pg_seen) begin
          cur_state <= tgt;
          st        <= IDLE;
        end else if (expired) begin
          pg_err <= 1'b1;
          st     <= FAULT;
        end else begin
          cnt <= cnt + TW'(1);
        end
        default: st <= FAULT;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int SW    = 2,
  parameter int VW    = 8,
  parameter int CW    = 4,
  parameter int VTOP  = 100,
  parameter int VSTEP = 10,
  parameter int CTOP  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pgood,
  input logic [VW-1:0] vreg_code,
  input logic [CW-1:0] clk_sel,
  input logic          busy,
  input logic [SW-1:0] cur_state,
  input logic          pg_err
);
  // R5
  clk_vs_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(clk_sel) * VSTEP <= int'(vreg_code) - VTOP + CTOP * VSTEP);

  // R3
  up_after_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel > $past(clk_sel)) |-> $past(pgood));

  // R11
  done_with_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !pg_err) |-> (cur_state != $past(cur_state)));

  // R10
  state_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != $past(cur_state)) |-> $past(busy));

  // R7
  fault_keeps_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_err) |-> $stable(clk_sel));
endmodule

bind dvfs_seq dvfs_seq_chk #(
  .SW(SW), .VW(VW), .CW(CW), .VTOP(VTOP), .VSTEP(VSTEP), .CTOP(CTOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pgood(pgood), .vreg_code(vreg_code),
  .clk_sel(clk_sel), .busy(busy), .cur_state(cur_state), .pg_err(pg_err)
);

// File: tb/dvfs_seq_bench.sv
module dvfs_seq_bench;
  localparam int PERIOD   = 10;
  localparam int LOCK_CYC = 4;
  localparam int PG_DLY   = 3;
  localparam int PG_LIMIT = 20;

  logic       clk = 0, rst_n = 0, req_valid = 0, therm_alarm = 0, pgood = 1;
  logic [1:0] req_state = 0;
  logic [15:0] pg_limit = 16'(PG_LIMIT);
  logic [7:0] vreg_code;
  logic [3:0] clk_sel;
  logic       busy, pg_err;
  logic [1:0] cur_state;

  dvfs_seq u_dvfs_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .therm_alarm(therm_alarm), .pgood(pgood), .pg_limit(pg_limit),
    .vreg_code(vreg_code), .clk_sel(clk_sel), .busy(busy),
    .cur_state(cur_state), .pg_err(pg_err)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, viol = 0, cyc = 0;
  bit finished = 0, pg_hold = 0;
  logic [9:0] q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int vc(input int i); return 100 - 10 * i; endfunction
  function automatic int cs(input int i); return 5 - i; endfunction

  task automatic expect_move(input int from, input int to);
    if (to < from) begin
      q.push_back({2'd0, 8'(vc(to))});
      q.push_back({2'd1, 8'(cs(to))});
    end else if (to > from) begin
      q.push_back({2'd1, 8'(cs(to))});
      q.push_back({2'd0, 8'(vc(to))});
    end
    if (to != from) q.push_back({2'd2, 8'(to)});
  endtask

  task automatic got(input logic [9:0] ev);
    logic [9:0] e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R3/R4/R10 unexpected event: actual %0h expected none", ev);
    end else begin
      e = q.pop_front();
      if (e != ev) begin
        errors++;
        $display("FAIL R2/R3/R4/R9 event order: actual %0h expected %0h", ev, e);
      end
    end
  endtask

  logic [7:0] pv; logic [3:0] pc; logic [1:0] ps; logic pe;
  int last_c = 0, last_v = 0, last_kind = 0, pg_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (vreg_code != pv) begin
        if (vreg_code < pv) chk("R4 volt lags clk by lock", cyc - last_c, LOCK_CYC);
        got({2'd0, vreg_code});
        last_v = cyc; last_kind = 0;
      end
      if (clk_sel != pc) begin
        if (clk_sel > pc) chk("R3 pgood before clk up", int'(pgood), 1);
        got({2'd1, 4'd0, clk_sel});
        last_c = cyc; last_kind = 1;
      end
      if (cur_state != ps) begin
        chk("R11 busy low at completion", int'(busy), 0);
        if (last_kind == 1) chk("R8 lock wait", cyc - last_c, LOCK_CYC);
        got({2'd2, 6'd0, cur_state});
        last_kind = 2;
      end
      if (pg_err && !pe) chk("R7 timeout window", cyc - last_v, PG_LIMIT);
      if (int'(clk_sel) * 10 > int'(vreg_code) - 50) viol++;
    end
    if (vreg_code != pv) begin pgood = 0; pg_cnt = PG_DLY; end
    else if (pg_cnt > 0) begin pg_cnt--; if (pg_cnt == 0 && !pg_hold) pgood = 1; end
    pv = vreg_code; pc = clk_sel; ps = cur_state; pe = pg_err;
  end

  task automatic req(input int s);
    @(negedge clk); req_valid = 1; req_state = 2'(s);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_reset();
    chk("R1 state", int'(cur_state), 3);
    chk("R1 vreg", int'(vreg_code), 70);
    chk("R1 clk", int'(clk_sel), 2);
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(pg_err), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      chk("R5 clk within voltage, violations", viol, 0);
      chk("R9 scoreboard drained", q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_reset();

    expect_move(3, 0);
    @(negedge clk); req_valid = 1; req_state = 0;
    @(negedge clk); req_valid = 0;
    chk("R11 busy rises", int'(busy), 1);
    wait_idle();
    chk("R2 P0 vreg", int'(vreg_code), 100);
    chk("R2 P0 clk", int'(clk_sel), 5);

    expect_move(0, 2);
    req(2);
    wait_idle();
    chk("R2 P2 vreg", int'(vreg_code), 80);
    chk("R2 P2 clk", int'(clk_sel), 3);

    req(2);
    chk("R10 busy stays low", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R10 state unchanged", int'(cur_state), 2);

    expect_move(2, 1);
    expect_move(1, 3);
    req(1);
    @(negedge clk);
    req(0);
    req(3);
    wait_idle();
    chk("R9 latest request served", int'(cur_state), 3);

    expect_move(3, 0);
    req(0);
    wait_idle();
    expect_move(0, 3);
    @(negedge clk); therm_alarm = 1;
    wait_idle();
    chk("R6 throttled", int'(cur_state), 3);
    req(1);
    repeat (10) @(negedge clk);
    chk("R6 request held off", int'(cur_state), 3);
    chk("R6 idle while alarm", int'(busy), 0);
    expect_move(3, 1);
    therm_alarm = 0;
    wait_idle();
    chk("R6 resumed request", int'(cur_state), 1);

    pg_hold = 1;
    q.push_back({2'd0, 8'(vc(0))});
    req(0);
    repeat (PG_LIMIT + 8) @(negedge clk);
    chk("R7 error flag", int'(pg_err), 1);
    chk("R7 clock kept", int'(clk_sel), 4);
    chk("R7 busy dropped", int'(busy), 0);
    chk("R7 state kept", int'(cur_state), 1);
    req(2);
    repeat (10) @(negedge clk);
    chk("R7 no move after fault", int'(cur_state), 1);

    pg_hold = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_reset();
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule